// File: doc/BRIEF.md
# Bus Clock Period Calibrator

This block works out the period of a bus clock whose frequency is not known in advance. Logic elsewhere divides that bus clock down into a square wave with a fixed programmed count. This block watches the wave and times it against a free-running reference counter of known frequency. After a start pulse it waits out two warm-up rising edges and stamps the reference counter. It lets a long window of wave cycles pass, stamps the counter again, and turns the difference into a fixed-point period per count tick.

The period arrives kept scaled by a count-divisor factor, so it holds more precision than a plain nanosecond figure. A sanity window bounds it. When the measured value falls outside the window, the block substitutes the period of a nominal default bus frequency and raises a flag instead of reporting an error. Downstream logic reads the period while `cal_valid` is high and uses it to set its own timing divisors.

With the default parameters the measured window is 256 wave cycles of 2*(63+1) ticks each. The count divisor is 4, so the sanity window runs from 53 (75 MHz) to 160 (25 MHz) and the default is 60 (66 MHz).

Top module: `bus_period_cal`

## Requirements
- R1: After reset `cal_valid`, `cal_fallback` and `cal_period` are all 0.
- R2: An edge is the square-wave input being 1 in a cycle after it was 0. Just after an accepted start the previous level counts as 1, so a wave that is already high at start produces no edge until it has been low.
- R3: The first two edges after a start are only warm-up. The start timestamp is the value of `ref_count` in the cycle of edge 2, so reference jumps before edge 2 do not change the result.
- R4: The end timestamp is the value of `ref_count` in the cycle of edge 258 (DISCARD + CYCLES). Measurement then stops, so reference jumps after that edge do not change the result.
- R5: The raw result is floor(D * 10^9 / (CYCLES * 2 * (WAVE_COUNT+1) * REF_HZ)), where D = end − start taken modulo 2^REF_W. A reference counter that wraps in the window still gives the right D.
- R6: A raw result in the inclusive range [4000/75 = 53, 4000/25 = 160] (1000*CNT_DIV/MHz, integer division) is output unchanged with `cal_fallback` = 0.
- R7: A raw result above 160 or below 53 is replaced by 4000/66 = 60, with `cal_fallback` = 1.
- R8: `cal_valid` is high for exactly one cycle per completed measurement, and `cal_period`/`cal_fallback` hold the result in that cycle.
- R9: An accepted start pulse clears `cal_period` and `cal_fallback` to 0 on the next clock edge.
- R10: A start pulse is ignored while a measurement or division is in progress, including in the same cycle as the final edge. In that case the running measurement completes with unchanged timing and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse to begin a calibration |
| sq_in | input | 1 | Square wave derived from the bus clock (already synchronised) |
| ref_count | input | REF_W | Free-running reference counter value |
| cal_period | output | RES_W | Scaled period per count tick |
| cal_valid | output | 1 | One-cycle pulse marking a new result |
| cal_fallback | output | 1 | Result is the substituted default |

## Verification
The collision of interest is a start pulse that lands in the very cycle the final measured edge arrives, so that ending a measurement and launching a new one compete for the same edge. The bench raises the wave and pulses start on the same clock. It then requires the result to appear after exactly as many clocks as in an undisturbed run, with the same value, which could not happen if the pulse had restarted the edge count. A pulse in mid-window is judged the same way. Reference-counter jumps placed just before the second edge and just after the last edge expose an off-by-one in either timestamp.

// File: rtl/bpc_pkg.sv
// Package: shared types and helper math for the bus period calibrator.
// Assumes integer MHz figures and a positive count divisor.
package bpc_pkg;

    // Edge sequencer state.
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_MEAS = 1'b1
    } seq_state_t;

    // Scaled period (ns * divisor) that belongs to a bus frequency in MHz.
    function automatic longint unsigned period_for_mhz(input longint unsigned mhz,
                                                       input longint unsigned div);
        return (64'd1000 * div) / mhz;
    endfunction

endpackage

// File: rtl/bpc_edge_seq.sv
// Edge sequencer: after launch, counts rising edges of sq_in, stamps the
// reference counter on edge DISCARD and again on edge DISCARD+CYCLES, then
// reports the modulo difference with a one-cycle done pulse.
// Assumes sq_in is already synchronous and DISCARD >= 1.
module bpc_edge_seq
    import bpc_pkg::*;
#(
    parameter int REF_W   = 32,
    parameter int DISCARD = 2,
    parameter int CYCLES  = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             sq_in,
    input  logic [REF_W-1:0] ref_count,
    output logic             busy,
    output logic             done,
    output logic [REF_W-1:0] delta
);
    localparam int END_EDGE = DISCARD + CYCLES;
    localparam int CW       = $clog2(END_EDGE + 1);

    seq_state_t       state;
    logic [CW-1:0]    edge_cnt;
    logic             prev_lvl;
    logic [REF_W-1:0] t_start;
    logic             rise;
    logic [CW-1:0]    cnt_next;

    assign busy     = (state == SEQ_MEAS);
    assign rise     = busy && sq_in && !prev_lvl;
    assign cnt_next = edge_cnt + 1'b1;

    // Track edges, capture both timestamps and finish on the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            edge_cnt <= '0;
            prev_lvl <= 1'b1;
            t_start  <= '0;
            delta    <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (launch && !busy) begin
                state    <= SEQ_MEAS;
                edge_cnt <= '0;
                prev_lvl <= 1'b1;
            end else if (busy) begin
                prev_lvl <= sq_in;
                if (rise) begin
                    edge_cnt <= cnt_next;
                    if (cnt_next == CW'(DISCARD))
                        t_start <= ref_count;
                    if (cnt_next == CW'(END_EDGE)) begin
                        delta <= ref_count - t_start;
                        state <= SEQ_IDLE;
                        done  <= 1'b1;
                    end
                end
            end
        end
    end

    AST_EDGE_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        edge_cnt <= CW'(END_EDGE)); // R4
    AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && (edge_cnt == CW'(END_EDGE))); // R4

endmodule

// File: rtl/bpc_divider.sv
// Restoring divider, one quotient bit per cycle, W cycles per divide.
// Assumes den is non-zero and stable while busy.
module bpc_divider #(
    parameter int W = 62
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int IW = $clog2(W + 1);

    logic [W:0]    rem;
    logic [W-1:0]  acc;
    logic [IW-1:0] iter;
    logic [W:0]    trial;
    logic          take;

    assign trial = {rem[W-1:0], acc[W-1]};
    assign take  = trial >= {1'b0, den};
    assign quo   = acc;

    // Load operands on go, then shift in one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            acc  <= '0;
            iter <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                rem  <= '0;
                acc  <= num;
                iter <= IW'(W);
                busy <= 1'b1;
            end else if (busy) begin
                rem  <= take ? (trial - {1'b0, den}) : trial;
                acc  <= {acc[W-2:0], take};
                iter <= iter - 1'b1;
                if (iter == IW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    AST_DIV_GO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        go && !busy |=> busy); // R5
    AST_DIV_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy)); // R5

endmodule

// File: rtl/bus_period_cal.sv
// Top: measures a bus-derived square wave against a reference counter and
// outputs a scaled period per count tick, substituting a default when the
// value is outside the sanity window.
// Assumes ref_count advances at REF_HZ and the wave period is
// 2*(WAVE_COUNT+1) bus-derived ticks.
module bus_period_cal
    import bpc_pkg::*;
#(
    parameter int              REF_W      = 32,
    parameter int              RES_W      = 16,
    parameter int              DISCARD    = 2,
    parameter int              CYCLES     = 256,
    parameter int              WAVE_COUNT = 63,
    parameter longint unsigned REF_HZ     = 64'd50_000_000,
    parameter int              CNT_DIV    = 4,
    parameter int              LOW_MHZ    = 25,
    parameter int              HIGH_MHZ   = 75,
    parameter int              DEF_MHZ    = 66
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sq_in,
    input  logic [REF_W-1:0] ref_count,
    output logic [RES_W-1:0] cal_period,
    output logic             cal_valid,
    output logic             cal_fallback
);
    localparam int              PROD_W  = REF_W + 30;
    localparam longint unsigned NS_SCL  = 64'd1_000_000_000;
    localparam longint unsigned DEN     = 64'(CYCLES) * 64'd2 * 64'(WAVE_COUNT + 1) * REF_HZ;
    localparam longint unsigned MAX_PER = period_for_mhz(64'(LOW_MHZ), 64'(CNT_DIV));
    localparam longint unsigned MIN_PER = period_for_mhz(64'(HIGH_MHZ), 64'(CNT_DIV));
    localparam longint unsigned DEF_PER = period_for_mhz(64'(DEF_MHZ), 64'(CNT_DIV));

    logic             seq_busy, seq_done;
    logic [REF_W-1:0] delta;
    logic             div_busy, div_done;
    logic [PROD_W-1:0] quo;
    logic [PROD_W-1:0] num;
    logic             launch;
    logic             out_of_range;

    // A start is accepted only when nothing is in flight.
    assign launch = start && !seq_busy && !seq_done && !div_busy && !div_done;
    // Multiply before dividing to keep the fraction.
    assign num    = PROD_W'(delta) * PROD_W'(NS_SCL);
    assign out_of_range = (quo > PROD_W'(MAX_PER)) || (quo < PROD_W'(MIN_PER));

    bpc_edge_seq #(
        .REF_W   (REF_W),
        .DISCARD (DISCARD),
        .CYCLES  (CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .sq_in     (sq_in),
        .ref_count (ref_count),
        .busy      (seq_busy),
        .done      (seq_done),
        .delta     (delta)
    );

    bpc_divider #(
        .W (PROD_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (seq_done),
        .num   (num),
        .den   (PROD_W'(DEN)),
        .busy  (div_busy),
        .done  (div_done),
        .quo   (quo)
    );

    // Register the checked result and its one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_period   <= '0;
            cal_valid    <= 1'b0;
            cal_fallback <= 1'b0;
        end else begin
            cal_valid <= 1'b0;
            if (launch) begin
                cal_period   <= '0;
                cal_fallback <= 1'b0;
            end else if (div_done) begin
                cal_valid    <= 1'b1;
                cal_fallback <= out_of_range;
                cal_period   <= out_of_range ? RES_W'(DEF_PER) : quo[RES_W-1:0];
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_valid |=> !cal_valid); // R8
    AST_VALID_AFTER_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        cal_valid |-> $past(div_done)); // R8
    AST_FALLBACK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_valid && cal_fallback |-> cal_period == RES_W'(DEF_PER)); // R7
    AST_RESULT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        cal_valid && !cal_fallback |->
            (64'(cal_period) <= MAX_PER) && (64'(cal_period) >= MIN_PER)); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        start && seq_busy |=> seq_busy || seq_done); // R10
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> cal_period == '0 && !cal_fallback); // R9

endmodule

// File: tb/bus_period_cal_tb_top.sv
// Directed bench: each task drives a square wave and reference counter and
// checks the calibrated period, flag and latency.
module bus_period_cal_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int JUMP       = 25600;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sq_in = 1'b0;
    logic [31:0] ref_v = '0;
    logic [15:0] cal_period;
    logic        cal_valid;
    logic        cal_fallback;

    int n_checks = 0;
    int n_fail   = 0;
    int base_lat = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_period_cal #(
        .REF_HZ (64'd7_812_500)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .sq_in        (sq_in),
        .ref_count    (ref_v),
        .cal_period   (cal_period),
        .cal_valid    (cal_valid),
        .cal_fallback (cal_fallback)
    );

    // Record one check.
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected output for a product p*k (ref step k, wave period p clocks).
    function automatic int exp_val(input int q);
        return (q > 160 || q < 53) ? 60 : q;
    endfunction

    // Drive one measurement; optional second start pulse at clock extra_n.
    task automatic run_meas(input int p, input int k, input bit hi, input int extra_n,
                            output int lat, output int res, output bit fb);
        bit seen = 0;
        int jump_ph = hi ? p/2 : 0;
        lat = -1; res = 0; fb = 0;
        for (int n = 0; n < 300*p + 400 && !seen; n++) begin
            int ph = n % p;
            int c  = n / p;
            @(negedge clk);
            if (n == 1)
                chk(cal_period == 0 && !cal_fallback, "R9", "cleared on start",
                    {cal_fallback, cal_period}, 0);
            if (n > 0 && cal_valid) begin
                seen = 1; lat = n; res = cal_period; fb = cal_fallback;
            end else begin
                sq_in = hi ? (ph < p/2) : (ph >= p/2);
                ref_v = ref_v + 32'(k) + ((ph == jump_ph && (c == 1 || c == 258)) ? 32'(JUMP) : 32'd0);
                start = (n == 0) || (n == extra_n);
            end
        end
        start = 0; sq_in = 0;
        chk(seen, "R8", "valid seen", seen, 1);
        @(negedge clk);
        chk(!cal_valid, "R8", "valid one cycle", cal_valid, 0);
    endtask

    // Plain run checking value and flag.
    task automatic t_value(input int p, input int k, input string req);
        int lat, res; bit fb;
        int e = exp_val(p*k);
        run_meas(p, k, 0, -1, lat, res, fb);
        chk(res == e, req, "period", res, e);
        chk(fb == (e != p*k), req, "fallback", fb, e != p*k);
    endtask

    // R3/R4/R5: main run with timestamp-boundary jumps, sets base latency.
    task automatic t_main;
        int lat, res; bit fb;
        ref_v = 0;
        run_meas(16, 5, 0, -1, lat, res, fb);
        base_lat = lat;
        chk(res == 80, "R3", "period with edge jumps", res, 80);
        chk(!fb, "R4", "no fallback", fb, 0);
    endtask

    // R2: wave high at start must not count as an edge.
    task automatic t_high_start;
        int lat, res; bit fb;
        run_meas(16, 5, 1, -1, lat, res, fb);
        chk(lat - base_lat == 8, "R2", "latency shift", lat - base_lat, 8);
        chk(res == 80, "R2", "period", res, 80);
    endtask

    // R5: reference counter wraps inside the window.
    task automatic t_wrap;
        int lat, res; bit fb;
        ref_v = 32'hFFFF_F000;
        run_meas(16, 7, 0, -1, lat, res, fb);
        chk(res == 112, "R5", "wrapped period", res, 112);
    endtask

    // R10: start pulse mid-window and on the final edge are both ignored.
    task automatic t_ignore(input int extra_n, input string what);
        int lat, res; bit fb;
        run_meas(16, 5, 0, extra_n, lat, res, fb);
        chk(lat == base_lat, "R10", {what, " latency"}, lat, base_lat);
        chk(res == 80, "R10", {what, " period"}, res, 80);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        for (int i = 0; i < WATCHDOG && !finished; i++) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cal_valid && !cal_fallback && cal_period == 0, "R1", "reset state",
            {cal_valid, cal_fallback, cal_period}, 0);
        t_main();
        t_high_start();
        t_value(16, 10, "R6");   // 160, top of window
        t_value(53, 1,  "R6");   // 53, bottom of window
        t_value(16, 3,  "R7");   // 48 -> default
        t_value(16, 11, "R7");   // 176 -> default
        t_value(16, 4,  "R6");   // 64, also checks clear after fallback (R9)
        t_wrap();
        t_ignore(16*100, "mid-window start");
        t_ignore(257*16 + 8, "start on final edge");
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule